// File: doc/BRIEF.md
# Double-Buffered Gamma Lookup Table

This block applies a per-channel gamma lookup to a red/green/blue pixel stream. It holds two banks of table storage, A and B, each with one table per channel. The pixel path reads from the active bank while the host fills the other bank through a small register port. Once the new table is in place, the host requests a bank change, and the change takes effect only at the next frame-start pulse. A frame is therefore never shown with a mix of old and new curves.

The register port has four word addresses: control, index, data and status. Each data write stores one entry at the current table index and then advances the index by one. The host can therefore stream a whole curve as back-to-back writes. A 3-bit channel mask picks which channel tables a data write updates. Writing the index register moves the write pointer, and writing 0 rewinds it before the next channel is loaded. The status register reports the mode and bank that the pixel path is using now. The host reads it to find the idle bank.

In bypass mode each pixel comes out one cycle after it enters, unchanged. In table mode the upper bits of each channel's pixel value form the table index. The stored entry of the active bank comes out one cycle later.

Top module: `gamma_dbuf_lut`

## Requirements
- R1: After reset, control reads 0x7000 (all mask bits set, every other field 0), index reads 0, status reads 0 (bypass, bank A), and all three pixel outputs are 0.
- R2: While the active mode is not 2, each pixel output equals that channel's pixel input one clock later.
- R3: While the active mode is 2, each pixel output one clock later equals the active bank's entry for that channel at index pix[15:10].
- R4: An accepted data write (address 2) stores reg_wdata into the current index and then increments the index. Incrementing from 63 wraps to 0.
- R5: A write to the index register (address 1) loads reg_wdata[5:0] into the index. A data write that follows goes to that entry.
- R6: Control bits [14:12] form the channel write mask: bit 14 enables red, bit 13 green and bit 12 blue (value 4 red, 2 green, 1 blue, 7 all). A data write leaves masked-off channels unchanged.
- R7: Control bit 8 picks the bank that receives host data writes (0 = A, 1 = B). Writes to the inactive bank do not change the displayed output.
- R8: Control bits [1:0] (pending mode) and bit 4 (pending display bank) reach the pixel path only on a cycle with frame_start high. Status (address 3) reports the active mode in bits [1:0] and the active bank in bit 4.
- R9: A data write aimed at the active bank while the active mode is 2 is discarded. The table does not change and the index does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Write address: 0 control, 1 index, 2 data |
| reg_wdata | input | 16 | Write data |
| reg_rd_addr | input | 2 | Read address: 0 control, 1 index, 3 status |
| reg_rdata | output | 16 | Combinational read data |
| frame_start | input | 1 | Single-cycle frame boundary pulse |
| pix_in_r | input | 16 | Red pixel input |
| pix_in_g | input | 16 | Green pixel input |
| pix_in_b | input | 16 | Blue pixel input |
| pix_out_r | output | 16 | Red pixel output |
| pix_out_g | output | 16 | Green pixel output |
| pix_out_b | output | 16 | Blue pixel output |

## Verification
A pixel result is due one clock after its input. The bench drives a pixel at a falling edge and compares the output at the next falling edge, with exactly one rising edge in between. Register writes, including index changes, are visible on the combinational readback right after the edge that accepts them. The bench reads them half a cycle after that edge. A mode or bank change is due only after the edge that samples frame_start. The bench therefore checks the output once before the pulse, expecting the old behaviour, and once after it, expecting the new.

// File: rtl/gamma_lut_pkg.sv
package gamma_lut_pkg;
    localparam int REG_W = 16;
    localparam int NCH   = 3;
    localparam int NBANK = 2;

    localparam logic [1:0] ADDR_CTRL   = 2'd0;
    localparam logic [1:0] ADDR_INDEX  = 2'd1;
    localparam logic [1:0] ADDR_DATA   = 2'd2;
    localparam logic [1:0] ADDR_STATUS = 2'd3;

    localparam logic [1:0] MODE_TABLE = 2'd2;

    localparam int CTRL_MODE_LO = 0;
    localparam int CTRL_SEL_BIT = 4;
    localparam int CTRL_HOST_BIT = 8;
    localparam int CTRL_MASK_LO = 12;
endpackage

// File: rtl/gamma_lut_chan_ram.sv
module gamma_lut_chan_ram #(
    parameter int DEPTH = 64,
    parameter int DW    = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/gamma_lut_ctrl.sv
module gamma_lut_ctrl
    import gamma_lut_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       addr,
    input  logic [REG_W-1:0] wdata,
    input  logic [1:0]       rd_addr,
    output logic [REG_W-1:0] rdata,
    input  logic             frame_start,
    output logic             act_table,
    output logic             act_sel,
    output logic             host_sel,
    output logic [NCH-1:0]   wmask,
    output logic [AW-1:0]    wr_idx,
    output logic             data_wr
);
    typedef struct packed {
        logic [1:0]     pend_mode;
        logic           pend_sel;
        logic           host_sel;
        logic [NCH-1:0] mask;
        logic [AW-1:0]  idx;
        logic [1:0]     act_mode;
        logic           act_sel;
    } ctrl_state_t;

    ctrl_state_t state_d, state_q;
    logic        blocked;

    always_comb begin
        state_d = state_q;
        blocked = (state_q.act_mode == MODE_TABLE) && (state_q.host_sel == state_q.act_sel);
        data_wr = 1'b0;
        if (wr_en) begin
            case (addr)
                ADDR_CTRL: begin
                    state_d.pend_mode = wdata[CTRL_MODE_LO +: 2];
                    state_d.pend_sel  = wdata[CTRL_SEL_BIT];
                    state_d.host_sel  = wdata[CTRL_HOST_BIT];
                    state_d.mask      = wdata[CTRL_MASK_LO +: NCH];
                end
                ADDR_INDEX: begin
                    state_d.idx = wdata[AW-1:0];
                end
                ADDR_DATA: begin
                    if (!blocked) begin
                        data_wr     = 1'b1;
                        state_d.idx = AW'(state_q.idx + 1'b1);
                    end
                end
                default: begin
                end
            endcase
        end
        if (frame_start) begin
            state_d.act_mode = state_q.pend_mode;
            state_d.act_sel  = state_q.pend_sel;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '{pend_mode: 2'd0, pend_sel: 1'b0, host_sel: 1'b0,
                         mask: {NCH{1'b1}}, idx: '0, act_mode: 2'd0, act_sel: 1'b0};
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        rdata = '0;
        case (rd_addr)
            ADDR_CTRL: begin
                rdata[CTRL_MODE_LO +: 2]   = state_q.pend_mode;
                rdata[CTRL_SEL_BIT]        = state_q.pend_sel;
                rdata[CTRL_HOST_BIT]       = state_q.host_sel;
                rdata[CTRL_MASK_LO +: NCH] = state_q.mask;
            end
            ADDR_INDEX: rdata[AW-1:0] = state_q.idx;
            ADDR_STATUS: begin
                rdata[CTRL_MODE_LO +: 2] = state_q.act_mode;
                rdata[CTRL_SEL_BIT]      = state_q.act_sel;
            end
            default: rdata = '0;
        endcase
    end

    assign act_table = (state_q.act_mode == MODE_TABLE);
    assign act_sel   = state_q.act_sel;
    assign host_sel  = state_q.host_sel;
    assign wmask     = state_q.mask;
    assign wr_idx    = state_q.idx;
endmodule

// File: rtl/gamma_dbuf_lut.sv
module gamma_dbuf_lut
    import gamma_lut_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int DW    = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr_en,
    input  logic [1:0]       reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    input  logic [1:0]       reg_rd_addr,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             frame_start,
    input  logic [DW-1:0]    pix_in_r,
    input  logic [DW-1:0]    pix_in_g,
    input  logic [DW-1:0]    pix_in_b,
    output logic [DW-1:0]    pix_out_r,
    output logic [DW-1:0]    pix_out_g,
    output logic [DW-1:0]    pix_out_b
);
    logic             act_table;
    logic             act_sel;
    logic             host_sel;
    logic [NCH-1:0]   wmask;
    logic [AW-1:0]    wr_idx;
    logic             data_wr;
    logic [NBANK-1:0] bank_we;
    logic [DW-1:0]    pix_in_arr [NCH];
    logic [DW-1:0]    rd_data    [NBANK][NCH];

    gamma_lut_ctrl #(.AW(AW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (reg_wr_en),
        .addr       (reg_addr),
        .wdata      (reg_wdata),
        .rd_addr    (reg_rd_addr),
        .rdata      (reg_rdata),
        .frame_start(frame_start),
        .act_table  (act_table),
        .act_sel    (act_sel),
        .host_sel   (host_sel),
        .wmask      (wmask),
        .wr_idx     (wr_idx),
        .data_wr    (data_wr)
    );

    assign pix_in_arr[0] = pix_in_r;
    assign pix_in_arr[1] = pix_in_g;
    assign pix_in_arr[2] = pix_in_b;

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        assign bank_we[b] = data_wr && (host_sel == b[0]);
        for (genvar c = 0; c < NCH; c++) begin : g_chan
            gamma_lut_chan_ram #(.DEPTH(DEPTH), .DW(DW)) u_ram (
                .clk  (clk),
                .we   (bank_we[b] && wmask[NCH-1-c]),
                .waddr(wr_idx),
                .wdata(reg_wdata[DW-1:0]),
                .raddr(pix_in_arr[c][DW-1 -: AW]),
                .rdata(rd_data[b][c])
            );
        end
    end

    typedef struct packed {
        logic [NCH-1:0][DW-1:0] pix;
    } out_state_t;

    out_state_t out_d, out_q;

    always_comb begin
        out_d = out_q;
        for (int c = 0; c < NCH; c++) begin
            out_d.pix[c] = act_table ? rd_data[act_sel][c] : pix_in_arr[c];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign pix_out_r = out_q.pix[0];
    assign pix_out_g = out_q.pix[1];
    assign pix_out_b = out_q.pix[2];
endmodule

// File: rtl/gamma_dbuf_lut_chk.sv
module gamma_dbuf_lut_chk #(
    parameter int AW = 6,
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          reg_wr_en,
    input logic [1:0]    reg_addr,
    input logic [15:0]   reg_wdata,
    input logic          frame_start,
    input logic [15:0]   reg_rdata,
    input logic [1:0]    reg_rd_addr,
    input logic [AW-1:0] wr_idx,
    input logic          data_wr,
    input logic          act_table,
    input logic          act_sel,
    input logic [1:0]    bank_we,
    input logic [DW-1:0] pix_in_r,
    input logic [DW-1:0] pix_out_r
);
    AST_IDX_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        data_wr |=> wr_idx == AW'($past(wr_idx) + 1'b1)); // R4

    AST_IDX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && reg_addr == 2'd1) |=> wr_idx == $past(reg_wdata[AW-1:0])); // R5

    AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> ($stable(act_table) && $stable(act_sel))); // R8

    AST_BYPASS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        !act_table |=> pix_out_r == $past(pix_in_r)); // R2

    AST_NO_ACTIVE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !(act_table && bank_we[act_sel])); // R9

    AST_BLOCKED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && reg_addr == 2'd2 && !data_wr) |=> $stable(wr_idx)); // R9
endmodule

bind gamma_dbuf_lut gamma_dbuf_lut_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr_en  (reg_wr_en),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .frame_start(frame_start),
    .reg_rdata  (reg_rdata),
    .reg_rd_addr(reg_rd_addr),
    .wr_idx     (wr_idx),
    .data_wr    (data_wr),
    .act_table  (act_table),
    .act_sel    (act_sel),
    .bank_we    (bank_we),
    .pix_in_r   (pix_in_r),
    .pix_out_r  (pix_out_r)
);

// File: tb/tb_gamma_dbuf_lut.sv
`timescale 1ns/1ps
module tb_gamma_dbuf_lut;
    localparam int DEPTH = 64;
    localparam int DW    = 16;
    localparam int AW    = $clog2(DEPTH);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [1:0]  reg_rd_addr = '0;
    logic [15:0] reg_rdata;
    logic        frame_start = 1'b0;
    logic [15:0] pix_in_r = '0, pix_in_g = '0, pix_in_b = '0;
    logic [15:0] pix_out_r, pix_out_g, pix_out_b;

    always #2 clk = ~clk;

    gamma_dbuf_lut dut (.*);

    int checks = 0;
    int fails  = 0;

    logic [15:0]   model [2][3][DEPTH];
    logic [AW-1:0] m_idx = '0;
    logic [2:0]    m_mask = 3'd7;
    logic          m_host = 1'b0;
    logic [1:0]    m_pmode = '0, m_amode = '0;
    logic          m_psel = 1'b0, m_asel = 1'b0;

    localparam logic [47:0] VEC [8] = '{
        {16'h0000, 16'hFFFF, 16'h2800},
        {16'h2800, 16'h0400, 16'h0000},
        {16'hFC00, 16'h1234, 16'h8001},
        {16'h5555, 16'hAAAA, 16'h2BFF},
        {16'h0BFF, 16'h7C00, 16'hC3C3},
        {16'h8000, 16'h0001, 16'hFFFF},
        {16'h1111, 16'h2222, 16'h3333},
        {16'hE0E0, 16'h0F0F, 16'h4400}
    };

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
        case (a)
            2'd0: begin
                m_pmode = d[1:0]; m_psel = d[4]; m_host = d[8]; m_mask = d[14:12];
            end
            2'd1: m_idx = d[AW-1:0];
            2'd2: if (!(m_amode == 2'd2 && m_host == m_asel)) begin
                for (int c = 0; c < 3; c++)
                    if (m_mask[2-c]) model[m_host][c][m_idx] = d;
                m_idx = m_idx + 1'b1;
            end
            default: ;
        endcase
    endtask

    task automatic reg_check(input logic [1:0] a, input logic [15:0] exp, input string tag);
        reg_rd_addr = a;
        #0.5;
        check(tag, reg_rdata, exp);
    endtask

    task automatic pulse_frame();
        @(negedge clk);
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        m_amode = m_pmode; m_asel = m_psel;
    endtask

    function automatic logic [15:0] expect_pix(input int c, input logic [15:0] p);
        if (m_amode == 2'd2) return model[m_asel][c][p[15:10]];
        return p;
    endfunction

    task automatic pix_check(input logic [47:0] v, input string tag);
        @(negedge clk);
        pix_in_r = v[47:32]; pix_in_g = v[31:16]; pix_in_b = v[15:0];
        @(negedge clk);
        check({tag, " red"},   pix_out_r, expect_pix(0, v[47:32]));
        check({tag, " green"}, pix_out_g, expect_pix(1, v[31:16]));
        check({tag, " blue"},  pix_out_b, expect_pix(2, v[15:0]));
    endtask

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        reg_check(2'd0, 16'h7000, "R1 ctrl reset");
        reg_check(2'd1, 16'h0000, "R1 index reset");
        reg_check(2'd3, 16'h0000, "R1 status reset");
        check("R1 out reset", pix_out_r | pix_out_g | pix_out_b, 16'h0000);
        rst_n = 1'b1;

        for (int i = 0; i < 8; i++) pix_check(VEC[i], "R2 bypass");

        // Bank A: all channels i*16+5, then green overwritten, then one blue entry
        reg_write(2'd0, 16'h7000);
        reg_write(2'd1, 16'h0000);
        for (int i = 0; i < DEPTH; i++) reg_write(2'd2, 16'(i * 16 + 5));
        reg_check(2'd1, 16'h0000, "R4 index wrap");
        reg_write(2'd0, 16'h2000);
        reg_write(2'd1, 16'h0000);
        for (int i = 0; i < DEPTH; i++) reg_write(2'd2, 16'(16'h8000 + i));
        reg_write(2'd0, 16'h1000);
        reg_write(2'd1, 16'h000A);
        reg_check(2'd1, 16'h000A, "R5 index load");
        reg_write(2'd2, 16'hBEEF);
        reg_check(2'd1, 16'h000B, "R4 index step");

        // Pending mode 2 on bank A, host to B
        reg_write(2'd0, 16'h7102);
        reg_check(2'd0, 16'h7102, "R8 ctrl readback");
        reg_check(2'd3, 16'h0000, "R8 status before frame");
        pix_check(VEC[0], "R8 still bypass");
        pulse_frame();
        reg_check(2'd3, 16'h0002, "R8 status after frame");
        for (int i = 0; i < 8; i++) pix_check(VEC[i], "R3 R6 table A");

        // Fill bank B while A is displayed
        reg_write(2'd1, 16'h0000);
        for (int i = 0; i < DEPTH; i++) reg_write(2'd2, 16'(16'h4000 + i));
        pix_check(VEC[2], "R7 inactive write hidden");

        // Write aimed at active bank A is dropped
        reg_write(2'd0, 16'h7002);
        reg_write(2'd1, 16'h0000);
        reg_write(2'd2, 16'h1234);
        reg_check(2'd1, 16'h0000, "R9 index held");
        pix_check(VEC[1], "R9 table unchanged");

        // Switch display to bank B
        reg_write(2'd0, 16'h7012);
        pix_check(VEC[3], "R8 A until frame");
        pulse_frame();
        reg_check(2'd3, 16'h0012, "R8 status bank B");
        for (int i = 0; i < 8; i++) pix_check(VEC[i], "R3 R7 table B");

        // Back to bypass
        reg_write(2'd0, 16'h7000);
        pulse_frame();
        for (int i = 0; i < 4; i++) pix_check(VEC[i], "R2 bypass again");

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule